// File: doc/BRIEF.md
# Branch-on-Index Execution Unit

This unit carries out the two index-stepping branch operations of a general-register processor. On a start pulse it reads a first operand, an increment and a compare value from its own sixteen-entry, 32-bit register file. It adds the increment to the first operand and compares the sum against the compare value as signed numbers. It then writes the sum back to the first-operand register and reports the address of the next instruction. Depending on the selected variant, the branch is taken when the sum is strictly greater than the compare value, or when it is less than or equal to it.

The third register number has two meanings. When it is even, it names a pair of registers: the even one holds the increment and the odd one holds the compare value. When it is odd, one register holds both values. The compare value is always the content the register had before the write-back. This holds even when the destination register is the compare register.

Decode and address generation sit upstream, so the branch target arrives already formed. A test port writes and reads the register file directly, which lets a bench preload operands and observe sums.

Top module: `bxi_unit`

## Requirements
- R1: After reset, busy_o and done_o are low, next_ia_o is zero and every register reads zero.
- R2: The wrapped 32-bit sum of first operand and increment is written to register r1_i whether or not the branch is taken, and overflow is ignored.
- R3: With variant_i = 0 (sum-high), next_ia_o is target_i when the signed sum is strictly greater than the compare value, otherwise seq_ia_i.
- R4: With variant_i = 1 (sum-low-or-equal), next_ia_o is target_i when the signed sum is less than or equal to the compare value, otherwise seq_ia_i.
- R5: An even r3_i takes the increment from register r3_i and the compare value from register r3_i+1.
- R6: An odd r3_i takes both increment and compare value from register r3_i.
- R7: When r1_i names the compare register, the comparison uses that register's content from before the write-back.
- R8: Addition and comparison are signed two's complement, so a sum that wraps past the largest positive value compares as negative.
- R9: A start accepted while idle raises busy_o for exactly one cycle. done_o then pulses high for one cycle, in the cycle after busy_o, together with the new next_ia_o.
- R10: A start pulse while busy_o is high is ignored: no second operation runs and no register changes.
- R11: target_i and seq_ia_i are captured with the start pulse. Later changes do not alter next_ia_o, which holds its value between operations.
- R12: A test write (tw_en_i) while idle updates the addressed register. tr_data_o shows register tr_addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| variant_i | input | 1 | 0 = branch when sum high, 1 = branch when sum low or equal |
| r1_i | input | 4 | First-operand and destination register number |
| r3_i | input | 4 | Increment/compare register number |
| target_i | input | 24 | Branch target address |
| seq_ia_i | input | 24 | Next sequential instruction address |
| tw_en_i | input | 1 | Test write enable |
| tw_addr_i | input | 4 | Test write register number |
| tw_data_i | input | 32 | Test write data |
| tr_addr_i | input | 4 | Test read register number |
| tr_data_o | output | 32 | Test read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| next_ia_o | output | 24 | Next instruction address |

## Verification
The bench aims first at the aliasing case, where the destination is the compare register. A design that compared against the freshly written sum would decide the opposite way on the chosen values. It also drives an increment that pushes the first operand past the largest positive value. An unsigned or overflow-checking compare would then branch wrongly in the sum-high variant. Equal sum and compare values separate the two variants; an off-by-one relation would swap the outcome. Odd register numbers, a start pulse raised mid-operation and inputs changed after capture each expose a wrong pair selection, a double execution or an uncaptured target.

// File: rtl/bxi_pkg.sv
package bxi_pkg;
    parameter int XLEN   = 32;
    parameter int AW     = 24;
    parameter int NREG   = 16;
    parameter int RIDX_W = $clog2(NREG);

    typedef enum logic {
        VAR_HIGH = 1'b0,
        VAR_LOE  = 1'b1
    } variant_e;

    typedef struct packed {
        logic              busy;
        logic              done;
        variant_e          variant;
        logic [RIDX_W-1:0] r1;
        logic [XLEN-1:0]   op1;
        logic [XLEN-1:0]   inc;
        logic [XLEN-1:0]   cmp;
        logic [AW-1:0]     tgt;
        logic [AW-1:0]     seq;
        logic [AW-1:0]     next_ia;
    } state_t;
endpackage

// File: rtl/bxi_regfile.sv
module bxi_regfile
    import bxi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] ra_addr,
    output logic [XLEN-1:0]   ra_data,
    input  logic [RIDX_W-1:0] rb_addr,
    output logic [XLEN-1:0]   rb_data,
    input  logic [RIDX_W-1:0] rc_addr,
    output logic [XLEN-1:0]   rc_data,
    input  logic [RIDX_W-1:0] rt_addr,
    output logic [XLEN-1:0]   rt_data,
    input  logic              ux_we,
    input  logic [RIDX_W-1:0] ux_addr,
    input  logic [XLEN-1:0]   ux_data,
    input  logic              tw_we,
    input  logic [RIDX_W-1:0] tw_addr,
    input  logic [XLEN-1:0]   tw_data
);
    logic [XLEN-1:0] regs_q [NREG];

    assign ra_data = regs_q[ra_addr];
    assign rb_data = regs_q[rb_addr];
    assign rc_data = regs_q[rc_addr];
    assign rt_data = regs_q[rt_addr];

    // Unit write-back takes priority over the test port.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (ux_we && ux_addr == RIDX_W'(g)) begin
                regs_q[g] <= ux_data;
            end else if (tw_we && tw_addr == RIDX_W'(g)) begin
                regs_q[g] <= tw_data;
            end
        end
    end
endmodule

// File: rtl/bxi_opsel.sv
module bxi_opsel
    import bxi_pkg::*;
(
    input  logic [RIDX_W-1:0] r3,
    output logic [RIDX_W-1:0] inc_idx,
    output logic [RIDX_W-1:0] cmp_idx
);
    // Even number: pair (r3, r3+1); odd number: r3 serves both roles.
    assign inc_idx = r3;
    assign cmp_idx = {r3[RIDX_W-1:1], 1'b1};
endmodule

// File: rtl/bxi_decide.sv
module bxi_decide
    import bxi_pkg::*;
(
    input  variant_e        variant,
    input  logic [XLEN-1:0] op1,
    input  logic [XLEN-1:0] inc,
    input  logic [XLEN-1:0] cmp,
    output logic [XLEN-1:0] sum,
    output logic            taken
);
    logic high;

    always_comb begin
        sum   = op1 + inc;
        high  = $signed(sum) > $signed(cmp);
        taken = (variant == VAR_HIGH) ? high : !high;
    end
endmodule

// File: rtl/bxi_unit.sv
module bxi_unit
    import bxi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              variant_i,
    input  logic [RIDX_W-1:0] r1_i,
    input  logic [RIDX_W-1:0] r3_i,
    input  logic [AW-1:0]     target_i,
    input  logic [AW-1:0]     seq_ia_i,
    input  logic              tw_en_i,
    input  logic [RIDX_W-1:0] tw_addr_i,
    input  logic [XLEN-1:0]   tw_data_i,
    input  logic [RIDX_W-1:0] tr_addr_i,
    output logic [XLEN-1:0]   tr_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [AW-1:0]     next_ia_o
);
    state_t st_d, st_q;

    logic [RIDX_W-1:0] inc_idx, cmp_idx;
    logic [XLEN-1:0]   op1_rd, inc_rd, cmp_rd;
    logic [XLEN-1:0]   sum;
    logic              taken;

    bxi_opsel u_opsel (
        .r3      (r3_i),
        .inc_idx (inc_idx),
        .cmp_idx (cmp_idx)
    );

    bxi_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (r1_i),
        .ra_data (op1_rd),
        .rb_addr (inc_idx),
        .rb_data (inc_rd),
        .rc_addr (cmp_idx),
        .rc_data (cmp_rd),
        .rt_addr (tr_addr_i),
        .rt_data (tr_data_o),
        .ux_we   (st_q.busy),
        .ux_addr (st_q.r1),
        .ux_data (sum),
        .tw_we   (tw_en_i && !st_q.busy),
        .tw_addr (tw_addr_i),
        .tw_data (tw_data_i)
    );

    bxi_decide u_decide (
        .variant (st_q.variant),
        .op1     (st_q.op1),
        .inc     (st_q.inc),
        .cmp     (st_q.cmp),
        .sum     (sum),
        .taken   (taken)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.busy    = 1'b0;
            st_d.done    = 1'b1;
            st_d.next_ia = taken ? st_q.tgt : st_q.seq;
        end else if (start_i) begin
            st_d.busy    = 1'b1;
            st_d.variant = variant_e'(variant_i);
            st_d.r1      = r1_i;
            st_d.op1     = op1_rd;
            st_d.inc     = inc_rd;
            st_d.cmp     = cmp_rd;
            st_d.tgt     = target_i;
            st_d.seq     = seq_ia_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign next_ia_o = st_q.next_ia;
endmodule

// File: rtl/bxi_unit_chk.sv
module bxi_unit_chk
    import bxi_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [AW-1:0] next_ia_o,
    input logic [AW-1:0] target_i,
    input logic [AW-1:0] seq_ia_i
);
    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> busy_o); // R9
    AST_BUSY_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (done_o && !busy_o)); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o)); // R9
    AST_IA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(next_ia_o)); // R11
    AST_IA_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (next_ia_o == $past(target_i, 2) || next_ia_o == $past(seq_ia_i, 2))); // R11
endmodule

bind bxi_unit bxi_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .next_ia_o (next_ia_o),
    .target_i  (target_i),
    .seq_ia_i  (seq_ia_i)
);

// File: tb/bxi_unit_bench.sv
module bxi_unit_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, variant_i;
    logic [3:0]  r1_i, r3_i;
    logic [23:0] target_i, seq_ia_i;
    logic        tw_en_i;
    logic [3:0]  tw_addr_i, tr_addr_i;
    logic [31:0] tw_data_i, tr_data_o;
    logic        busy_o, done_o;
    logic [23:0] next_ia_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model [16];

    always #(CLK_P/2) clk = ~clk;

    bxi_unit u_bxi_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .variant_i(variant_i),
        .r1_i(r1_i), .r3_i(r3_i), .target_i(target_i), .seq_ia_i(seq_ia_i),
        .tw_en_i(tw_en_i), .tw_addr_i(tw_addr_i), .tw_data_i(tw_data_i),
        .tr_addr_i(tr_addr_i), .tr_data_o(tr_data_o),
        .busy_o(busy_o), .done_o(done_o), .next_ia_o(next_ia_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int idx, input logic [31:0] val);
        tw_en_i = 1'b1; tw_addr_i = 4'(idx); tw_data_i = val;
        @(negedge clk);
        tw_en_i = 1'b0;
        model[idx] = val;
    endtask

    task automatic read_check(input int idx, input string req);
        tr_addr_i = 4'(idx);
        #1;
        check(tr_data_o === model[idx], req, tr_data_o, model[idx]);
    endtask

    // One operation; the model predicts outcome from the requirements.
    task automatic run_op(input bit loe, input int r1, input int r3,
                          input logic [23:0] tgt, input logic [23:0] seq,
                          input bit disturb, input string req);
        logic [31:0] inc, cmp, sum;
        bit          high, tk;
        logic [23:0] exp_ia;
        inc    = model[r3];
        cmp    = r3[0] ? model[r3] : model[r3 + 1];
        sum    = model[r1] + inc;
        high   = $signed(sum) > $signed(cmp);
        tk     = loe ? !high : high;
        exp_ia = tk ? tgt : seq;
        start_i = 1'b1; variant_i = loe; r1_i = 4'(r1); r3_i = 4'(r3);
        target_i = tgt; seq_ia_i = seq;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1 && done_o === 1'b0, "R9 busy", {30'd0, busy_o, done_o}, 32'h2);
        if (disturb) begin
            // R10 / R11: new start and changed addresses while busy
            start_i = 1'b1; r1_i = 4'(r3); r3_i = 4'(r1);
            target_i = ~tgt; seq_ia_i = ~seq; variant_i = ~loe;
        end
        @(negedge clk);
        start_i = 1'b0;
        check(done_o === 1'b1 && busy_o === 1'b0, "R9 done", {30'd0, busy_o, done_o}, 32'h1);
        check(next_ia_o === exp_ia, req, {8'd0, next_ia_o}, {8'd0, exp_ia});
        model[r1] = sum;
        read_check(r1, "R2 sum written");
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0, "R10 no second op", {30'd0, busy_o, done_o}, 32'h0);
        check(next_ia_o === exp_ia, "R11 next_ia held", {8'd0, next_ia_o}, {8'd0, exp_ia});
    endtask

    task automatic t_reset;
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 flags", {30'd0, busy_o, done_o}, 32'h0);
        check(next_ia_o === 24'd0, "R1 next_ia", {8'd0, next_ia_o}, 32'h0);
        read_check(3, "R1 reg zero");
        read_check(15, "R1 reg zero");
    endtask

    task automatic t_pair_high;
        wr_reg(2, 32'd10); wr_reg(4, 32'd5); wr_reg(5, 32'd12);
        read_check(4, "R12 test write");
        run_op(1'b0, 2, 4, 24'hA00010, 24'h000104, 1'b0, "R3 R5 high taken");
        wr_reg(2, 32'd3);
        run_op(1'b0, 2, 4, 24'hA00020, 24'h000108, 1'b0, "R3 high not taken");
    endtask

    task automatic t_loe_equal;
        wr_reg(6, 32'd7); wr_reg(8, 32'd3); wr_reg(9, 32'd10);
        run_op(1'b1, 6, 8, 24'hB00000, 24'h000200, 1'b0, "R4 equal taken");
        wr_reg(6, 32'd7);
        run_op(1'b0, 6, 8, 24'hB00004, 24'h000204, 1'b0, "R3 equal not taken");
        wr_reg(6, 32'd8);
        run_op(1'b1, 6, 8, 24'hB00008, 24'h000208, 1'b0, "R4 high not taken");
    endtask

    task automatic t_odd;
        wr_reg(1, -32'sd10); wr_reg(7, 32'd3);
        run_op(1'b0, 1, 7, 24'hC00000, 24'h000300, 1'b0, "R6 odd high");
        wr_reg(1, 32'd1);
        run_op(1'b1, 1, 7, 24'hC00010, 24'h000310, 1'b0, "R6 odd loe");
    endtask

    task automatic t_alias;
        wr_reg(12, 32'd1); wr_reg(13, 32'd5);
        run_op(1'b0, 13, 12, 24'hD00000, 24'h000400, 1'b0, "R7 alias pair");
        wr_reg(9, 32'd4);
        run_op(1'b0, 9, 9, 24'hD00010, 24'h000410, 1'b0, "R7 alias odd");
    endtask

    task automatic t_overflow;
        wr_reg(10, 32'h7FFF_FFFF); wr_reg(14, 32'd1); wr_reg(15, 32'd0);
        run_op(1'b0, 10, 14, 24'hE00000, 24'h000500, 1'b0, "R8 wrap high");
        wr_reg(10, 32'h7FFF_FFFF);
        run_op(1'b1, 10, 14, 24'hE00010, 24'h000510, 1'b0, "R8 wrap loe");
        read_check(10, "R2 wrapped sum");
    endtask

    task automatic t_busy;
        wr_reg(3, 32'd20); wr_reg(0, 32'd1); wr_reg(1, 32'd100);
        run_op(1'b1, 3, 0, 24'hF00000, 24'h000600, 1'b1, "R11 captured target");
        read_check(0, "R10 reg untouched");
    endtask

    initial begin
        bit wd_hit = 0;
        fork
            begin
                rst_n = 1'b0; start_i = 0; variant_i = 0; r1_i = 0; r3_i = 0;
                target_i = 0; seq_ia_i = 0; tw_en_i = 0; tw_addr_i = 0;
                tw_data_i = 0; tr_addr_i = 0;
                for (int i = 0; i < 16; i++) model[i] = 32'd0;
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_pair_high();
                t_loe_equal();
                t_odd();
                t_alias();
                t_overflow();
                t_busy();
            end
            begin
                repeat (5000) @(negedge clk);
                wd_hit = 1;
            end
        join_any
        disable fork;
        if (wd_hit) check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule